// File: doc/BRIEF.md
# Memory-Mapped Serial Port

This block is an asynchronous serial transceiver that a processor reaches through three word registers on a simple load/store bus with a valid/ready handshake. A store to the transmit word sends one byte as an 8N1 frame: one start bit, eight data bits with the least significant bit first, and one stop bit. A load from the receive word returns the oldest byte the receiver has collected and removes it from a small receive queue. A load from the status word shows whether the transmitter is still sending and whether a received byte is waiting.

The receive line passes through a two-flop synchronizer. It is then sampled on a tick that runs at sixteen times the baud rate, and each bit is taken at the middle of its period. Frames with a bad stop bit are discarded. Bytes that arrive while the queue is full are dropped. The bus response is registered: each accepted request is answered with `bus_ready` in the next cycle. A master must hold its request until it sees `bus_ready`, and must not depend on that latency. Only address bits 3:2 select a register, so the block can sit anywhere inside its address window.

Top module: `mmio_serial_port`

## Requirements
- R1: While reset is held and in the cycle after it is released, `txd` is high (idle mark), `bus_ready` is low and the status word reads zero.
- R2: A request is accepted when `bus_valid` is high and `bus_ready` is low. `bus_ready` is then high for exactly one cycle, in the cycle after acceptance, and carries the read data.
- R3: A store to offset 0x0 while the transmitter is idle sends bits 7:0 of the stored data as an 8N1 frame. Every bit lasts 16*TICK_DIV clocks. Status bit 0 is 1 from the cycle after acceptance until the stop bit has been sent.
- R4: A store to offset 0x0 while status bit 0 is 1 is ignored. The frame in flight is not changed, and no second frame follows it.
- R5: The receiver takes each bit at the middle sample of the 16x oversampled, synchronized line. A frame with a good stop bit (high) places its byte in the receive queue, and status bit 1 reads 1 while the queue is not empty.
- R6: A load from offset 0x4 returns the oldest queued byte in bits 7:0 with bits 31:8 zero, and removes that byte from the queue.
- R7: A load from offset 0x4 while the queue is empty returns zero and changes nothing.
- R8: A frame whose stop bit samples low is discarded and does not enter the queue. The receiver then waits for the line to go high before it looks for the next start bit.
- R9: The queue holds RX_DEPTH bytes in arrival order. A byte that completes while the queue is full is dropped.
- R10: The status word at offset 0x8 has bit 0 = transmitter busy and bit 1 = byte available, with bits 31:2 zero. Offset 0xC reads zero. Stores to offsets 0x4, 0x8 and 0xC have no effect. Every read returns zero in bits 31:8.
- R11: Only address bits 3:2 select a register. Bits 1:0 and the bits above bit 3 are ignored, as are bits 31:8 of stored data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_valid | input | 1 | Request present; held until `bus_ready` |
| bus_write | input | 1 | 1 = store, 0 = load |
| bus_addr | input | ADDR_W | Byte address within the window; bits 3:2 decode |
| bus_wdata | input | 32 | Store data; only bits 7:0 are used |
| bus_ready | output | 1 | One-cycle response strobe |
| bus_rdata | output | 32 | Load data, valid while `bus_ready` is high |
| txd | output | 1 | Serial transmit line, idle high |
| rxd | input | 1 | Serial receive line, asynchronous |

## Verification
The assertions watch the bus response shape on every cycle: `bus_ready` is a single-cycle pulse that only follows a request, and read data is never wider than a byte. They also check that the transmit line rests at mark when idle and drops to a start bit when a frame begins, that a store to the idle transmitter raises busy, and that the receive queue never overfills and is never popped while empty. Only the scenarios can show the actual bit values on `txd`, that a store during a frame is ignored, that bad-stop frames vanish, that the queue keeps arrival order, and that the fifth byte into a full queue is lost.

// File: rtl/sport_pkg.sv
// Shared constants and types for the serial port.
// Assumes a 32-bit bus and word registers selected by address bits 3:2.
package sport_pkg;
    localparam logic [1:0] WORD_TXD  = 2'd0;
    localparam logic [1:0] WORD_RXD  = 2'd1;
    localparam logic [1:0] WORD_STAT = 2'd2;

    localparam int STAT_TX_BUSY  = 0;
    localparam int STAT_RX_AVAIL = 1;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_HUNT
    } rx_state_e;
endpackage

// File: rtl/sport_tx.sv
// Transmit shifter: sends one 8N1 frame per start pulse, LSB first.
// Keeps its own bit-period counter so that every bit is exactly BIT_CLKS
// clocks long. Ignores start while a frame is in flight.
module sport_tx #(
    parameter int BIT_CLKS = 432
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] data,
    output logic       busy,
    output logic       txd
);
    localparam int CW = $clog2(BIT_CLKS);

    logic [CW-1:0] clk_cnt;
    logic [3:0]    bits_left;
    logic [8:0]    shreg;

    // Frame sequencing: load on start, shift one bit per period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            txd       <= 1'b1;
            shreg     <= '1;
            clk_cnt   <= '0;
            bits_left <= '0;
        end else if (start && !busy) begin
            busy      <= 1'b1;
            txd       <= 1'b0;
            shreg     <= {1'b1, data};
            clk_cnt   <= '0;
            bits_left <= 4'd9;
        end else if (busy) begin
            if (clk_cnt == CW'(BIT_CLKS - 1)) begin
                clk_cnt <= '0;
                if (bits_left == 4'd0) begin
                    busy <= 1'b0;
                    txd  <= 1'b1;
                end else begin
                    txd       <= shreg[0];
                    shreg     <= {1'b1, shreg[8:1]};
                    bits_left <= bits_left - 4'd1;
                end
            end else begin
                clk_cnt <= clk_cnt + CW'(1);
            end
        end
    end

    AST_TX_IDLE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd) else $error("idle line not high"); // R1

    AST_TX_START_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !txd) else $error("frame did not open with start bit"); // R3
endmodule

// File: rtl/sport_rx.sv
// Receiver: two-flop synchronizer, 16x oversampling tick, mid-bit sampling.
// Emits a one-cycle byte_valid pulse for each frame with a good stop bit.
// After each frame (good or bad) it waits for mark before hunting a start.
// Assumes TICK_DIV >= 2.
module sport_rx
    import sport_pkg::*;
#(
    parameter int TICK_DIV = 27
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rxd,
    output logic       byte_valid,
    output logic [7:0] byte_data
);
    localparam int TW = $clog2(TICK_DIV);

    logic          rx_meta, rx_s;
    logic [TW-1:0] div_cnt;
    logic          tick;
    rx_state_e     state;
    logic [3:0]    sub_cnt;
    logic [2:0]    bit_idx;
    logic [7:0]    shreg;

    // Bring the asynchronous line into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_meta <= 1'b1;
            rx_s    <= 1'b1;
        end else begin
            rx_meta <= rxd;
            rx_s    <= rx_meta;
        end
    end

    // Free-running oversampling tick generator.
    always_ff @(posedge clk) begin
        if (!rst_n)                          div_cnt <= '0;
        else if (div_cnt == TW'(TICK_DIV-1)) div_cnt <= '0;
        else                                 div_cnt <= div_cnt + TW'(1);
    end
    assign tick = (div_cnt == TW'(TICK_DIV - 1));

    // Frame recognition state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= RX_HUNT;
            sub_cnt    <= '0;
            bit_idx    <= '0;
            shreg      <= '0;
            byte_valid <= 1'b0;
        end else begin
            byte_valid <= 1'b0;
            case (state)
                RX_HUNT: if (rx_s) state <= RX_IDLE;
                RX_IDLE: if (tick && !rx_s) begin
                    state   <= RX_START;
                    sub_cnt <= '0;
                end
                RX_START: if (tick) begin
                    if (sub_cnt == 4'd7) begin
                        sub_cnt <= '0;
                        bit_idx <= '0;
                        state   <= rx_s ? RX_IDLE : RX_DATA;
                    end else begin
                        sub_cnt <= sub_cnt + 4'd1;
                    end
                end
                RX_DATA: if (tick) begin
                    sub_cnt <= sub_cnt + 4'd1;
                    if (sub_cnt == 4'd15) begin
                        shreg <= {rx_s, shreg[7:1]};
                        if (bit_idx == 3'd7) state <= RX_STOP;
                        bit_idx <= bit_idx + 3'd1;
                    end
                end
                RX_STOP: if (tick) begin
                    sub_cnt <= sub_cnt + 4'd1;
                    if (sub_cnt == 4'd15) begin
                        byte_valid <= rx_s;
                        state      <= RX_HUNT;
                    end
                end
                default: state <= RX_HUNT;
            endcase
        end
    end
    assign byte_data = shreg;

    AST_RX_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> !byte_valid) else $error("byte strobe longer than a cycle"); // R5
endmodule

// File: rtl/sport_fifo.sv
// Receive queue: DEPTH entries of W bits, first in first out.
// A push when full and a pop when empty are ignored. Any DEPTH >= 2.
module sport_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int AW   = $clog2(DEPTH);
    localparam int CNTW = $clog2(DEPTH + 1);

    logic [W-1:0]    mem [DEPTH];
    logic [AW-1:0]   wr_ptr, rd_ptr;
    logic [CNTW-1:0] count;
    logic            do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CNTW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    // Pointer and occupancy bookkeeping with explicit wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + AW'(1);
            if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + AW'(1);
            case ({do_push, do_pop})
                2'b10:   count <= count + CNTW'(1);
                2'b01:   count <= count - CNTW'(1);
                default: count <= count;
            endcase
        end
    end

    AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        full && push && !pop |=> full) else $error("occupancy moved past depth"); // R9

    AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        empty && pop && !push |=> empty) else $error("pop from empty queue"); // R7
endmodule

// File: rtl/mmio_serial_port.sv
// Memory-mapped serial port with transmit, receive and status words.
// Registered bus response: each accepted request gets bus_ready one cycle
// later. Decodes address bits 3:2 only. Assumes ADDR_W > 4.
module mmio_serial_port
    import sport_pkg::*;
#(
    parameter int CLK_HZ   = 50_000_000,
    parameter int BAUD     = 115_200,
    parameter int ADDR_W   = 12,
    parameter int RX_DEPTH = 4,
    parameter int TICK_DIV = CLK_HZ / (BAUD * 16)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic              bus_ready,
    output logic [31:0]       bus_rdata,
    output logic              txd,
    input  logic              rxd
);
    localparam int BIT_CLKS = TICK_DIV * 16;

    logic        rsp_q;
    logic [31:0] rdata_q;
    logic        accept;
    logic [1:0]  word;
    logic        tx_start, tx_busy;
    logic        rx_vld;
    logic [7:0]  rx_byte;
    logic        fifo_pop, fifo_empty, fifo_full;
    logic [7:0]  fifo_head;
    logic [31:0] rd_mux;
    logic        unused_bits;

    assign accept   = bus_valid && !rsp_q;
    assign word     = bus_addr[3:2];
    assign tx_start = accept && bus_write && (word == WORD_TXD);
    assign fifo_pop = accept && !bus_write && (word == WORD_RXD) && !fifo_empty;
    assign unused_bits = ^{bus_addr[ADDR_W-1:4], bus_addr[1:0], bus_wdata[31:8], fifo_full};

    // Read data selection for the addressed word.
    always_comb begin
        rd_mux = '0;
        if (!bus_write) begin
            case (word)
                WORD_RXD:  rd_mux[7:0] = fifo_empty ? 8'h00 : fifo_head;
                WORD_STAT: begin
                    rd_mux[STAT_TX_BUSY]  = tx_busy;
                    rd_mux[STAT_RX_AVAIL] = !fifo_empty;
                end
                default:   rd_mux = '0;
            endcase
        end
    end

    // Registered one-cycle bus response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            rsp_q <= accept;
            if (accept) rdata_q <= rd_mux;
        end
    end
    assign bus_ready = rsp_q;
    assign bus_rdata = rdata_q;

    sport_tx #(.BIT_CLKS(BIT_CLKS)) u_tx (
        .clk(clk), .rst_n(rst_n), .start(tx_start), .data(bus_wdata[7:0]),
        .busy(tx_busy), .txd(txd)
    );

    sport_rx #(.TICK_DIV(TICK_DIV)) u_rx (
        .clk(clk), .rst_n(rst_n), .rxd(rxd),
        .byte_valid(rx_vld), .byte_data(rx_byte)
    );

    sport_fifo #(.DEPTH(RX_DEPTH), .W(8)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(rx_vld), .wdata(rx_byte),
        .pop(fifo_pop), .head(fifo_head), .empty(fifo_empty), .full(fifo_full)
    );

    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |=> !bus_ready) else $error("ready held two cycles"); // R2

    AST_READY_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |-> $past(bus_valid)) else $error("ready without request"); // R2

    AST_RDATA_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |-> (bus_rdata[31:8] == 24'h0)) else $error("read data wider than a byte"); // R10

    AST_TX_WRITE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start && !tx_busy |=> tx_busy) else $error("store to idle transmitter did not start"); // R3
endmodule

// File: tb/mmio_serial_port_tb.sv
module mmio_serial_port_tb;
    localparam int TD  = 4;
    localparam int BIT = 16 * TD;
    localparam int DEP = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_valid, bus_write;
    logic [11:0] bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_ready;
    logic [31:0] bus_rdata;
    logic        txd;
    logic        rxd;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    mmio_serial_port #(.ADDR_W(12), .RX_DEPTH(DEP), .TICK_DIV(TD)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
        .bus_rdata(bus_rdata), .txd(txd), .rxd(rxd)
    );

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [31:0] wdata;
        logic [31:0] exp;
    } vec_t;

    // Idle-state register accesses; reads compare against exp.
    localparam vec_t VECS [9] = '{
        '{1'b0, 12'h008, 32'h0,        32'h0},  // R1 status zero after reset
        '{1'b0, 12'h004, 32'h0,        32'h0},  // R7 empty read
        '{1'b0, 12'h00C, 32'h0,        32'h0},  // R10 spare word
        '{1'b1, 12'h008, 32'hFFFFFFFF, 32'h0},  // R10 store to status
        '{1'b0, 12'h008, 32'h0,        32'h0},  // R10 status unchanged
        '{1'b1, 12'h004, 32'h000000AB, 32'h0},  // R10 store to rx word
        '{1'b0, 12'h004, 32'h0,        32'h0},  // R10 queue still empty
        '{1'b0, 12'h10B, 32'h0,        32'h0},  // R11 aliased status
        '{1'b0, 12'h205, 32'h0,        32'h0}   // R11 aliased rx word
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus(input logic wr, input logic [11:0] addr, input logic [31:0] wd,
                       output logic [31:0] rd);
        int waited = 0;
        @(negedge clk);
        bus_valid = 1'b1; bus_write = wr; bus_addr = addr; bus_wdata = wd;
        do begin
            @(posedge clk); #1;
            waited++;
        end while (!bus_ready && waited < 20);
        rd = bus_rdata;
        chk("R2 response latency", waited, 1);
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic cap_tx(output logic [7:0] b, output logic stopb, output logic startb);
        do @(negedge clk); while (txd);
        repeat (BIT / 2) @(negedge clk);
        startb = txd;
        for (int i = 0; i < 8; i++) begin
            repeat (BIT) @(negedge clk);
            b[i] = txd;
        end
        repeat (BIT) @(negedge clk);
        stopb = txd;
    endtask

    task automatic send_rx(input logic [7:0] b, input logic good_stop);
        @(negedge clk); rxd = 1'b0;
        repeat (BIT) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (BIT) @(negedge clk);
        end
        rxd = good_stop;
        repeat (BIT) @(negedge clk);
        rxd = 1'b1;
        repeat (2 * BIT) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R2 watchdog: actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic [7:0]  got;
        logic        stb, stt;
        rst_n = 1'b0; rxd = 1'b1; bus_valid = 1'b0; bus_write = 1'b0;
        bus_addr = '0; bus_wdata = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R1 txd in reset", {31'b0, txd}, 32'h1);
        chk("R1 ready in reset", {31'b0, bus_ready}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 txd after reset", {31'b0, txd}, 32'h1);

        foreach (VECS[i]) begin
            bus(VECS[i].wr, VECS[i].addr, VECS[i].wdata, rd);
            if (!VECS[i].wr) chk($sformatf("R10/R11 vector %0d", i), rd, VECS[i].exp);
        end

        // R3 frame, R4 ignored store during the frame
        fork
            cap_tx(got, stb, stt);
            begin
                bus(1'b1, 12'h000, 32'h0000003C, rd);
                bus(1'b0, 12'h008, 32'h0, rd);
                chk("R3 busy during frame", rd, 32'h1);
                bus(1'b1, 12'h000, 32'h000000A5, rd);
            end
        join
        chk("R3 start bit", {31'b0, stt}, 32'h0);
        chk("R4 frame data unchanged", {24'b0, got}, 32'h3C);
        chk("R3 stop bit", {31'b0, stb}, 32'h1);
        repeat (BIT) @(negedge clk);
        bus(1'b0, 12'h008, 32'h0, rd);
        chk("R3 busy clears", rd, 32'h0);
        repeat (2 * BIT) @(negedge clk);
        chk("R4 no second frame", {31'b0, txd}, 32'h1);

        // R11 aliased address and high data bits ignored
        fork
            cap_tx(got, stb, stt);
            bus(1'b1, 12'h101, 32'hFFFFFF5A, rd);
        join
        chk("R11 aliased tx byte", {24'b0, got}, 32'h5A);
        repeat (2 * BIT) @(negedge clk);

        // R5 / R6 / R7 receive path
        send_rx(8'hC3, 1'b1);
        bus(1'b0, 12'h008, 32'h0, rd);
        chk("R5 byte available", rd, 32'h2);
        bus(1'b0, 12'h004, 32'h0, rd);
        chk("R6 rx byte", rd, 32'hC3);
        bus(1'b0, 12'h008, 32'h0, rd);
        chk("R6 pop empties", rd, 32'h0);
        bus(1'b0, 12'h004, 32'h0, rd);
        chk("R7 empty read", rd, 32'h0);

        // R8 bad stop discarded, then recovery
        send_rx(8'h77, 1'b0);
        bus(1'b0, 12'h008, 32'h0, rd);
        chk("R8 bad frame not queued", rd, 32'h0);
        send_rx(8'h11, 1'b1);
        bus(1'b0, 12'h004, 32'h0, rd);
        chk("R8 next frame received", rd, 32'h11);

        // R9 ordering and drop on full
        send_rx(8'h01, 1'b1);
        send_rx(8'h82, 1'b1);
        send_rx(8'h43, 1'b1);
        send_rx(8'hF4, 1'b1);
        send_rx(8'h99, 1'b1);
        bus(1'b0, 12'h004, 32'h0, rd); chk("R9 order 0", rd, 32'h01);
        bus(1'b0, 12'h004, 32'h0, rd); chk("R9 order 1", rd, 32'h82);
        bus(1'b0, 12'h004, 32'h0, rd); chk("R9 order 2", rd, 32'h43);
        bus(1'b0, 12'h004, 32'h0, rd); chk("R9 order 3", rd, 32'hF4);
        bus(1'b0, 12'h004, 32'h0, rd); chk("R9 overflow dropped", rd, 32'h00);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule